// File: doc/BRIEF.md
# Independent Countdown Watchdog with Prescaled Slow Clock

This block is a watchdog timer that runs from its own slow, free-running clock rather than the bus clock. Once armed, a down-counter decrements once per prescaled slow-clock tick. If software fails to refresh it in time, the counter reaches zero and the block raises a one-cycle reset request. There is no way to disarm the watchdog except a full reset.

Software reaches it through four word locations on the bus clock:

- **Key location (0):** takes command words that arm, refresh or unlock the block.
- **Divider-select location (1):** holds a 3-bit exponent.
- **Reload location (2):** holds a 12-bit reload value.
- **Status location (3):** read-only.

The divider-select and reload locations are guarded. They accept writes only after the unlock key has been given.

Each accepted update, and each refresh, is carried into the slow domain by a toggle handshake with two-flop synchronizers in both directions. A busy flag stays up until the acknowledge has come back. The timeout equals (reload + 1) × 4 × 2^exponent slow-clock periods.

Top module: `iwdg_top`

## Requirements
- R1: After reset:
  - location 1 reads 0;
  - location 2 reads 0xFFF;
  - locations 0 and 3 read 0;
  - `osc_keep_on` and `wdg_rst` are low.
- R2: Writing 0xCCCC to location 0 arms the watchdog. Status bit 3 and `osc_keep_on` then read 1 and stay 1 whatever key is written later, and reset requests keep coming.
- R3: Writes to location 1 (bits [2:0]) and location 2 (bits [11:0]) take effect only after the key 0x5555. Any other key word locks them again, and a write while locked leaves the stored value unchanged.
- R4: The status busy flags are bit 0 for location 1, bit 1 for location 2 and bit 2 for a pending refresh. An accepted write raises its flag from the next bus cycle until the slow-domain acknowledge returns. A write to that location while its flag is up is ignored.
- R5: While armed and not refreshed, the distance between consecutive `wdg_rst` pulses is exactly (reload + 1) × 4 × 2^exponent slow-clock cycles.
- R6: Every `wdg_rst` pulse is high for exactly one slow-clock cycle.
- R7: The key 0xAAAA refreshes the watchdog. When it reaches the slow domain, the counter is reloaded and the prescaler restarts. Refreshing more often than the timeout prevents any reset request. The next request after a final refresh comes one full timeout plus the synchronizer latency later.
- R8: Before the watchdog is armed, `wdg_rst` never rises, whatever the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the register side |
| lsi_clk | input | 1 | Slow independent counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 2 | Location select: 0 key, 1 divider exponent, 2 reload, 3 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for the selected location |
| osc_keep_on | output | 1 | Request that the slow clock source stay on; set when armed, never cleared |
| wdg_rst | output | 1 | Reset request, one slow-clock cycle per timeout |

## Verification
The properties assume three things about the inputs:

- `rst_n` is applied to both domains together.
- Each write strobe lasts one bus cycle.
- The slow clock is several times slower than the bus clock. The one-cycle `arrive` and `busy` properties rely on the round trip of the handshake being longer than a slow cycle.

The stimulus keeps to these conditions:

- It drives writes at the falling bus edge with a 20 ns bus clock and a 100 ns slow clock.
- It waits for all busy flags to clear before reprogramming.
- It only writes a location while that location is busy when it is deliberately checking that the write is dropped.

// File: rtl/iwdg_pkg.sv
package iwdg_pkg;

   localparam int          KEY_W      = 16;
   localparam logic [15:0] KEY_ARM    = 16'hCCCC;
   localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
   localparam logic [15:0] KEY_OPEN   = 16'h5555;

   typedef enum logic [1:0] {
      LOC_KEY    = 2'd0,
      LOC_DIVSEL = 2'd1,
      LOC_RELOAD = 2'd2,
      LOC_STATUS = 2'd3
   } loc_e;

   // handshake channel indices
   localparam int CH_DIV  = 0;
   localparam int CH_RLD  = 1;
   localparam int CH_FEED = 2;
   localparam int NUM_CH  = 3;

endpackage

// File: rtl/iwdg_sync.sv
module iwdg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("iwdg_sync: STAGES must be 2 or more");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/iwdg_xfer.sv
module iwdg_xfer #(
   parameter int STAGES = 2
) (
   input  logic bus_clk,
   input  logic slow_clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic arrive
);

   logic req_t, req_s, ack_t, ack_s;

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                req_t <= 1'b0;
      else if (launch && !busy)  req_t <= ~req_t;
   end

   iwdg_sync #(.STAGES(STAGES)) u_req_sync (
      .clk   (slow_clk),
      .rst_n (rst_n),
      .d     (req_t),
      .q     (req_s)
   );

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) ack_t <= 1'b0;
      else        ack_t <= req_s;
   end

   assign arrive = req_s ^ ack_t;

   iwdg_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk   (bus_clk),
      .rst_n (rst_n),
      .d     (ack_t),
      .q     (ack_s)
   );

   assign busy = req_t ^ ack_s;

   // R4: a launch accepted while idle shows up as busy on the next bus cycle
   a_r4_busy_after_launch: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (launch && !busy) |=> busy);

   // R4: each transfer is delivered to the slow side as a single-cycle event
   a_r4_arrive_single: assert property (@(posedge slow_clk) disable iff (!rst_n)
      arrive |=> !arrive);

endmodule

// File: rtl/iwdg_bus_regs.sv
module iwdg_bus_regs
   import iwdg_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter int              PR_W     = 3,
   parameter int              RL_W     = 12,
   parameter logic [RL_W-1:0] RL_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NUM_CH-1:0] busy,
   output logic [NUM_CH-1:0] launch,
   output logic [PR_W-1:0]   pr_q,
   output logic [RL_W-1:0]   rl_q,
   output logic              run_q
);

   loc_e loc;
   logic wr_key, wr_div, wr_rld, is_arm, is_refresh, is_open, unlocked;

   assign loc        = loc_e'(addr);
   assign wr_key     = wr_en && (loc == LOC_KEY);
   assign is_arm     = (wdata == DATA_W'(KEY_ARM));
   assign is_refresh = (wdata == DATA_W'(KEY_REFRESH));
   assign is_open    = (wdata == DATA_W'(KEY_OPEN));
   assign wr_div     = wr_en && (loc == LOC_DIVSEL) && unlocked && !busy[CH_DIV];
   assign wr_rld     = wr_en && (loc == LOC_RELOAD) && unlocked && !busy[CH_RLD];

   always_comb begin
      launch          = '0;
      launch[CH_DIV]  = wr_div;
      launch[CH_RLD]  = wr_rld;
      launch[CH_FEED] = wr_key && is_refresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         run_q    <= 1'b0;
         pr_q     <= '0;
         rl_q     <= RL_RESET;
      end else begin
         if (wr_key)           unlocked <= is_open;
         if (wr_key && is_arm) run_q    <= 1'b1;
         if (wr_div)           pr_q     <= wdata[PR_W-1:0];
         if (wr_rld)           rl_q     <= wdata[RL_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (loc)
         LOC_DIVSEL: rdata[PR_W-1:0] = pr_q;
         LOC_RELOAD: rdata[RL_W-1:0] = rl_q;
         LOC_STATUS: begin
            rdata[0] = busy[CH_DIV];
            rdata[1] = busy[CH_RLD];
            rdata[2] = busy[CH_FEED];
            rdata[3] = run_q;
         end
         default:    rdata = '0;
      endcase
   end

   a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);

   a_r3_locked_reload_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && loc == LOC_RELOAD && !unlocked) |=> $stable(rl_q));

   a_r3_locked_divsel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && loc == LOC_DIVSEL && !unlocked) |=> $stable(pr_q));

   a_r4_busy_divsel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && loc == LOC_DIVSEL && busy[CH_DIV]) |=> $stable(pr_q));

   a_r4_busy_reload_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && loc == LOC_RELOAD && busy[CH_RLD]) |=> $stable(rl_q));

endmodule

// File: rtl/iwdg_core.sv
module iwdg_core #(
   parameter int              PR_W        = 3,
   parameter int              RL_W        = 12,
   parameter int              SYNC_STAGES = 2,
   parameter logic [RL_W-1:0] RL_RESET    = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_a,
   input  logic [PR_W-1:0] pr_in,
   input  logic [RL_W-1:0] rl_in,
   input  logic            pr_arrive,
   input  logic            rl_arrive,
   input  logic            feed_arrive,
   output logic            wdg_rst
);

   // largest division is 4 * 2^(2^PR_W - 1) = 2^(2^PR_W + 1)
   localparam int DIV_W = (1 << PR_W) + 1;

   logic              run_s;
   logic [PR_W-1:0]   pr_act;
   logic [RL_W-1:0]   rl_act;
   logic [RL_W-1:0]   cnt;
   logic [DIV_W-1:0]  div_cnt;
   logic [DIV_W:0]    div_full;
   logic [DIV_W-1:0]  div_lim;
   logic              tick;

   iwdg_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (run_a),
      .q     (run_s)
   );

   assign div_full = (DIV_W+1)'(4) << pr_act;
   assign div_lim  = DIV_W'(div_full - 1'b1);
   assign tick     = (div_cnt == div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_act  <= '0;
         rl_act  <= RL_RESET;
         cnt     <= RL_RESET;
         div_cnt <= '0;
         wdg_rst <= 1'b0;
      end else begin
         wdg_rst <= 1'b0;
         if (pr_arrive) pr_act <= pr_in;
         if (rl_arrive) rl_act <= rl_in;
         if (!run_s || feed_arrive) begin
            div_cnt <= '0;
            cnt     <= rl_act;
         end else begin
            if (pr_arrive || tick) div_cnt <= '0;
            else                   div_cnt <= div_cnt + 1'b1;
            if (tick) begin
               if (cnt == '0) begin
                  wdg_rst <= 1'b1;
                  cnt     <= rl_act;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
      end
   end

   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst |=> !wdg_rst);

   a_r8_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !run_s |=> !wdg_rst);

   a_r5_pulse_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdg_rst) |-> ($past(cnt) == '0));

   a_r2_run_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
      run_s |=> run_s);

endmodule

// File: rtl/iwdg_top.sv
module iwdg_top
   import iwdg_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int PR_W        = 3,
   parameter int RL_W        = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              lsi_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              osc_keep_on,
   output logic              wdg_rst
);

   localparam logic [RL_W-1:0] RL_RESET = '1;

   generate
      if (DATA_W < KEY_W) begin : g_bad_data_w
         $error("iwdg_top: DATA_W must hold a full key word");
      end
      if (RL_W > DATA_W || RL_W < 2) begin : g_bad_rl_w
         $error("iwdg_top: RL_W must be between 2 and DATA_W");
      end
      if (PR_W < 1 || PR_W > 4) begin : g_bad_pr_w
         $error("iwdg_top: PR_W must be between 1 and 4");
      end
   endgenerate

   logic [NUM_CH-1:0] launch, busy, arrive;
   logic [PR_W-1:0]   pr_q;
   logic [RL_W-1:0]   rl_q;
   logic              run_q;

   iwdg_bus_regs #(
      .DATA_W   (DATA_W),
      .PR_W     (PR_W),
      .RL_W     (RL_W),
      .RL_RESET (RL_RESET)
   ) u_regs (
      .clk    (bus_clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .busy   (busy),
      .launch (launch),
      .pr_q   (pr_q),
      .rl_q   (rl_q),
      .run_q  (run_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      iwdg_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
         .bus_clk  (bus_clk),
         .slow_clk (lsi_clk),
         .rst_n    (rst_n),
         .launch   (launch[c]),
         .busy     (busy[c]),
         .arrive   (arrive[c])
      );
   end

   iwdg_core #(
      .PR_W        (PR_W),
      .RL_W        (RL_W),
      .SYNC_STAGES (SYNC_STAGES),
      .RL_RESET    (RL_RESET)
   ) u_core (
      .clk         (lsi_clk),
      .rst_n       (rst_n),
      .run_a       (run_q),
      .pr_in       (pr_q),
      .rl_in       (rl_q),
      .pr_arrive   (arrive[CH_DIV]),
      .rl_arrive   (arrive[CH_RLD]),
      .feed_arrive (arrive[CH_FEED]),
      .wdg_rst     (wdg_rst)
   );

   assign osc_keep_on = run_q;

   a_r2_keep_on_sticky: assert property (@(posedge bus_clk) disable iff (!rst_n)
      osc_keep_on |=> osc_keep_on);

endmodule

// File: tb/iwdg_top_tb_top.sv
module iwdg_top_tb_top;

   logic        bus_clk = 1'b0;
   logic        lsi_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        wr_en   = 1'b0;
   logic [1:0]  addr    = 2'd0;
   logic [15:0] wdata   = 16'd0;
   logic [15:0] rdata;
   logic        osc_keep_on;
   logic        wdg_rst;

   always #10 bus_clk = ~bus_clk;   // 50 MHz
   always #50 lsi_clk = ~lsi_clk;   // slow clock, 10 MHz

   iwdg_top dut_i (
      .bus_clk     (bus_clk),
      .lsi_clk     (lsi_clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .addr        (addr),
      .wdata       (wdata),
      .rdata       (rdata),
      .osc_keep_on (osc_keep_on),
      .wdg_rst     (wdg_rst)
   );

   int checks = 0;
   int errors = 0;

   // slow-domain monitor, sampled on the falling edge
   int   slow_cnt  = 0;
   int   pulse_cnt = 0;
   int   last_pulse = 0;
   int   last_gap  = 0;
   int   width_err = 0;
   logic prev_rst  = 1'b0;

   always @(negedge lsi_clk) begin
      slow_cnt = slow_cnt + 1;
      if (wdg_rst) begin
         if (prev_rst) width_err = width_err + 1;
         else begin
            last_gap   = slow_cnt - last_pulse;
            last_pulse = slow_cnt;
            pulse_cnt  = pulse_cnt + 1;
         end
      end
      prev_rst = wdg_rst;
   end

   typedef struct packed {
      int pr;
      int rl;
      int period;
   } vec_t;

   // period = (rl + 1) * 4 * 2^pr slow cycles
   localparam vec_t VEC [6] = '{
      '{0, 3, 16},
      '{1, 2, 24},
      '{2, 0, 16},
      '{3, 1, 64},
      '{0, 0, 4},
      '{7, 0, 512}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge bus_clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge bus_clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [15:0] s;
      int n = 0;
      s = 16'hFFFF;
      while (s[2:0] != 3'b000 && n < 2000) begin
         bus_rd(2'd3, s);
         n++;
      end
      chk(req, int'(s[2:0]), 0);
   endtask

   task automatic wait_pulses(input int n, input int limit, input string req);
      int start = pulse_cnt;
      int t = 0;
      while (pulse_cnt < start + n && t < limit) begin
         @(negedge lsi_clk);
         #1 t++;
      end
      if (pulse_cnt < start + n) chk(req, pulse_cnt - start, n);
   endtask

   initial begin
      repeat (190000) @(posedge bus_clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int pc0;
      int t_feed;

      repeat (5) @(negedge bus_clk);
      rst_n = 1'b1;
      repeat (3) @(negedge bus_clk);

      // R1 reset state
      bus_rd(2'd1, d); chk("R1 divsel", int'(d), 0);
      bus_rd(2'd2, d); chk("R1 reload", int'(d), 16'hFFF);
      bus_rd(2'd3, d); chk("R1 status", int'(d), 0);
      bus_rd(2'd0, d); chk("R1 key reads zero", int'(d), 0);
      chk("R1 osc_keep_on", int'(osc_keep_on), 0);
      chk("R1 wdg_rst", int'(wdg_rst), 0);

      // R3 locked write ignored
      bus_wr(2'd2, 16'h0123);
      bus_rd(2'd2, d); chk("R3 locked write", int'(d), 16'hFFF);
      // R3 unlock then relock with another key
      bus_wr(2'd0, 16'h5555);
      bus_wr(2'd0, 16'h1234);
      bus_wr(2'd2, 16'h00AB);
      bus_rd(2'd2, d); chk("R3 relocked write", int'(d), 16'hFFF);

      // R4 busy flags and write-while-busy
      bus_wr(2'd0, 16'h5555);
      bus_wr(2'd2, 16'h0005);
      bus_rd(2'd3, d); chk("R4 reload busy set", int'(d[1]), 1);
      bus_wr(2'd2, 16'h0007);
      bus_wr(2'd1, 16'h0002);
      bus_rd(2'd3, d); chk("R4 divsel busy set", int'(d[0]), 1);
      wait_idle("R4 busy clears");
      bus_rd(2'd2, d); chk("R4 busy write dropped", int'(d), 5);
      bus_rd(2'd1, d); chk("R3 unlocked divsel write", int'(d), 2);

      // R8 no pulse before arming (timeout would be 6*16=96 slow cycles)
      repeat (2000) @(negedge bus_clk);
      chk("R8 no pulse before arm", pulse_cnt, 0);
      chk("R8 keep_on low before arm", int'(osc_keep_on), 0);

      // R5 vector table
      for (int i = 0; i < 6; i++) begin
         bus_wr(2'd0, 16'h5555);
         bus_wr(2'd1, 16'(VEC[i].pr));
         bus_wr(2'd2, 16'(VEC[i].rl));
         wait_idle("R4 idle before vector");
         if (i == 0) bus_wr(2'd0, 16'hCCCC);
         wait_pulses(1, 6000, "R5 first pulse");
         wait_pulses(1, 6000, "R5 second pulse");
         chk($sformatf("R5 period vec%0d", i), last_gap, VEC[i].period);
      end

      // R2 cannot be stopped
      bus_wr(2'd0, 16'h0000);
      bus_wr(2'd0, 16'h5555);
      bus_wr(2'd0, 16'hFFFF);
      bus_rd(2'd3, d); chk("R2 status running", int'(d[3]), 1);
      chk("R2 osc_keep_on held", int'(osc_keep_on), 1);
      pc0 = pulse_cnt;
      wait_pulses(2, 3000, "R2 pulses continue");
      chk("R2 pulses continue", int'(pulse_cnt >= pc0 + 2), 1);

      // R7 refresh: divsel 0, reload 15 -> 64 slow cycles
      bus_wr(2'd0, 16'h5555);
      bus_wr(2'd1, 16'h0000);
      bus_wr(2'd2, 16'h000F);
      wait_idle("R4 idle before refresh");
      for (int k = 0; k < 3; k++) begin
         bus_wr(2'd0, 16'hAAAA);
         repeat (100) @(negedge bus_clk);
      end
      pc0 = pulse_cnt;
      for (int k = 0; k < 30; k++) begin
         bus_wr(2'd0, 16'hAAAA);
         repeat (100) @(negedge bus_clk);
      end
      chk("R7 refresh prevents pulse", pulse_cnt - pc0, 0);
      bus_wr(2'd0, 16'hAAAA);
      t_feed = slow_cnt;
      wait_pulses(1, 500, "R7 pulse after last refresh");
      chk("R7 pulse delay in window",
          int'((last_pulse - t_feed) >= 64 && (last_pulse - t_feed) <= 71), 1);

      // R6 single-cycle pulses across all of the above
      chk("R6 pulse width one slow cycle", width_err, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule